// File: doc/BRIEF.md
# Precision Time Counter with Fractional Rate Accumulator

This block keeps a 64-bit time of day for a packet timestamping path. The value has two fields: 32 bits of whole seconds and 32 bits of nanoseconds. The counter is not advanced directly by its reference clock. A 32-bit phase accumulator adds a programmable addend on every reference cycle. Each carry out of that accumulator is a tick, and each tick adds a programmable nanosecond increment to the time. Software trims the counting rate by rewriting the addend.

Two staging registers hold a seconds value and a nanoseconds value. An initialize pulse copies them into the time counter as an absolute time. An update pulse instead applies them as a one-shot offset, added or subtracted according to a direction input. Carries and borrows between the nanoseconds and seconds fields are handled as decimal rollover at one billion nanoseconds.

Top module: `ptp_time_counter`

## Requirements
- R1: While reset is applied and on release, `time_sec`, `time_ns` and `tick` are all zero, and the addend, accumulator and staging registers are zero.
- R2: A cycle with `stage_we` high captures `stage_sec`/`stage_ns`; a cycle with `init_pulse` high makes the time equal the staged values after that clock edge, ignoring any tick in the same cycle.
- R3: A cycle with `adj_pulse` high and `adj_sub` low adds the staged seconds and nanoseconds to the time; a nanoseconds sum of 1,000,000,000 or more subtracts 1,000,000,000 and carries one second.
- R4: A cycle with `adj_pulse` high and `adj_sub` high subtracts the staged offset; a nanoseconds result below zero adds 1,000,000,000 and borrows one second. The seconds field wraps modulo 2^32.
- R5: Every reference cycle the accumulator adds the addend modulo 2^32. `tick` is high exactly in a cycle whose sum carries out of bit 31. With no tick and no pulse, the time does not change.
- R6: An addend written with `addend_we` is used from the following cycle on. The accumulator remainder is kept across the write.
- R7: Each tick adds the 8-bit `incr_ns` value to the nanoseconds field.
- R8: When a tick takes the nanoseconds field to 1,000,000,000 or beyond, 1,000,000,000 is subtracted from it and the seconds field increments.
- R9: When `init_pulse` and `adj_pulse` are high in the same cycle, only the initialize takes effect.
- R10: When an update and a tick fall in the same cycle, both the offset and the increment are applied, followed by a single rollover correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addend_we | input | 1 | Write strobe for the rate addend |
| addend_wdata | input | 32 | New addend value |
| incr_ns | input | 8 | Nanoseconds added per tick |
| stage_we | input | 1 | Write strobe for both staging registers |
| stage_sec | input | 32 | Staged seconds value or offset |
| stage_ns | input | 32 | Staged nanoseconds value or offset |
| init_pulse | input | 1 | Load the time from the staging registers |
| adj_pulse | input | 1 | Apply the staging registers as an offset |
| adj_sub | input | 1 | Offset direction: 0 add, 1 subtract |
| tick | output | 1 | Accumulator carry in this cycle |
| time_sec | output | 32 | Current seconds |
| time_ns | output | 32 | Current nanoseconds |

## Verification
Two pairs of events can collide in one cycle. An offset update can land on the same edge as an accumulator carry, and an initialize can land on the same edge as an update. The bench uses an addend of one quarter of full scale, so the carry cycles are known, and it places update pulses both on and off those cycles. It also raises both pulses together. A behavioural model then decides whether the increment was folded in, whether the update was dropped, and whether one rollover correction was applied. That result is compared against the live time on every clock.

// File: rtl/ptp_time_pkg.sv
package ptp_time_pkg;
  localparam logic [31:0] NS_PER_SEC = 32'd1_000_000_000;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_STEP = 2'd2
  } time_op_e;
endpackage

// File: rtl/ptp_rate_accum.sv
module ptp_rate_accum #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addend_we,
  input  logic [ACC_W-1:0] addend_wdata,
  output logic             tick
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W-1:0] addend_q, addend_d;
  logic             carry;

  always_comb begin
    {carry, acc_d} = {1'b0, acc_q} + {1'b0, addend_q};
    addend_d       = addend_we ? addend_wdata : addend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      addend_q <= '0;
    end else begin
      acc_q    <= acc_d;
      addend_q <= addend_d;
    end
  end

  assign tick = carry;

  AST_CARRY_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (acc_q < $past(acc_q))); // R5
  AST_NO_CARRY_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (acc_q >= $past(acc_q))); // R5
  AST_ADDEND_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    addend_we |=> (addend_q == $past(addend_wdata))); // R6
endmodule

// File: rtl/ptp_time_adjust.sv
module ptp_time_adjust #(
  parameter int SEC_W = 32,
  parameter int NS_W  = 32,
  parameter int INC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [INC_W-1:0] incr_ns,
  input  logic             init_pulse,
  input  logic             adj_pulse,
  input  logic             adj_sub,
  input  logic [SEC_W-1:0] off_sec,
  input  logic [NS_W-1:0]  off_ns,
  output logic [SEC_W-1:0] sec_q,
  output logic [NS_W-1:0]  ns_q
);
  import ptp_time_pkg::*;

  localparam int XW = NS_W + 3;
  localparam logic signed [XW-1:0] NS_LIM = $signed(XW'(NS_PER_SEC));

  time_op_e               op;
  logic signed [XW-1:0]   ns_raw, ns_fix;
  logic [SEC_W-1:0]       sec_raw, sec_fix;
  logic [SEC_W-1:0]       sec_d;
  logic [NS_W-1:0]        ns_d;
  logic                   en;

  always_comb begin
    if (init_pulse)              op = OP_LOAD;
    else if (adj_pulse || tick)  op = OP_STEP;
    else                         op = OP_HOLD;
  end

  always_comb begin
    ns_raw  = $signed({3'b000, ns_q});
    sec_raw = sec_q;
    if (tick) ns_raw = ns_raw + $signed(XW'(incr_ns));
    if (adj_pulse) begin
      if (adj_sub) begin
        ns_raw  = ns_raw - $signed({3'b000, off_ns});
        sec_raw = sec_q - off_sec;
      end else begin
        ns_raw  = ns_raw + $signed({3'b000, off_ns});
        sec_raw = sec_q + off_sec;
      end
    end
    if (ns_raw < 0) begin
      ns_fix  = ns_raw + NS_LIM;
      sec_fix = sec_raw - 1'b1;
    end else if (ns_raw >= NS_LIM) begin
      ns_fix  = ns_raw - NS_LIM;
      sec_fix = sec_raw + 1'b1;
    end else begin
      ns_fix  = ns_raw;
      sec_fix = sec_raw;
    end
  end

  always_comb begin
    en    = (op != OP_HOLD);
    sec_d = sec_q;
    ns_d  = ns_q;
    case (op)
      OP_LOAD: begin sec_d = off_sec;  ns_d = off_ns;              end
      OP_STEP: begin sec_d = sec_fix;  ns_d = ns_fix[NS_W-1:0];    end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      ns_q  <= '0;
    end else if (en) begin
      sec_q <= sec_d;
      ns_q  <= ns_d;
    end
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !init_pulse && !adj_pulse) |=> ($stable(sec_q) && $stable(ns_q))); // R5
  AST_INIT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    init_pulse |=> (sec_q == $past(off_sec) && ns_q == $past(off_ns))); // R2
  AST_TICK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !init_pulse && !adj_pulse && ns_q < NS_PER_SEC) |=> (ns_q < NS_PER_SEC)); // R8
  AST_TICK_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !init_pulse && !adj_pulse) |=> ((sec_q - $past(sec_q)) <= 1)); // R8
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter #(
  parameter int ACC_W = 32,
  parameter int SEC_W = 32,
  parameter int NS_W  = 32,
  parameter int INC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addend_we,
  input  logic [ACC_W-1:0] addend_wdata,
  input  logic [INC_W-1:0] incr_ns,
  input  logic             stage_we,
  input  logic [SEC_W-1:0] stage_sec,
  input  logic [NS_W-1:0]  stage_ns,
  input  logic             init_pulse,
  input  logic             adj_pulse,
  input  logic             adj_sub,
  output logic             tick,
  output logic [SEC_W-1:0] time_sec,
  output logic [NS_W-1:0]  time_ns
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [SEC_W-1:0] hold_sec_q, hold_sec_d;
  logic [NS_W-1:0]  hold_ns_q, hold_ns_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    hold_sec_d = stage_we ? stage_sec : hold_sec_q;
    hold_ns_d  = stage_we ? stage_ns  : hold_ns_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hold_sec_q <= '0;
      hold_ns_q  <= '0;
    end else begin
      hold_sec_q <= hold_sec_d;
      hold_ns_q  <= hold_ns_d;
    end
  end

  ptp_rate_accum #(.ACC_W(ACC_W)) u_accum (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .addend_we    (addend_we),
    .addend_wdata (addend_wdata),
    .tick         (tick)
  );

  ptp_time_adjust #(.SEC_W(SEC_W), .NS_W(NS_W), .INC_W(INC_W)) u_adjust (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .tick       (tick),
    .incr_ns    (incr_ns),
    .init_pulse (init_pulse),
    .adj_pulse  (adj_pulse),
    .adj_sub    (adj_sub),
    .off_sec    (hold_sec_q),
    .off_ns     (hold_ns_q),
    .sec_q      (time_sec),
    .ns_q       (time_ns)
  );

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_int_n |-> (time_sec == '0 && time_ns == '0 && !tick)); // R1
  AST_INIT_WINS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (init_pulse && adj_pulse) |=> (time_sec == $past(hold_sec_q) && time_ns == $past(hold_ns_q))); // R9
endmodule

// File: tb/ptp_time_counter_bench.sv
module ptp_time_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        addend_we;
  logic [31:0] addend_wdata;
  logic [7:0]  incr_ns;
  logic        stage_we;
  logic [31:0] stage_sec, stage_ns;
  logic        init_pulse, adj_pulse, adj_sub;
  logic        tick;
  logic [31:0] time_sec, time_ns;

  int    vectors = 0;
  int    errors  = 0;
  string req     = "R1";
  bit    done    = 0;

  longint m_acc, m_add, m_sec, m_ns, m_hsec, m_hns;
  bit     m_tick;

  always #2.5 clk = ~clk;

  ptp_time_counter u_ptp_time_counter (
    .clk(clk), .rst_n(rst_n), .addend_we(addend_we), .addend_wdata(addend_wdata),
    .incr_ns(incr_ns), .stage_we(stage_we), .stage_sec(stage_sec), .stage_ns(stage_ns),
    .init_pulse(init_pulse), .adj_pulse(adj_pulse), .adj_sub(adj_sub),
    .tick(tick), .time_sec(time_sec), .time_ns(time_ns)
  );

  // Behavioural reference model
  always_comb m_tick = (m_acc + m_add) >= 64'h1_0000_0000;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_add = 0; m_sec = 0; m_ns = 0; m_hsec = 0; m_hns = 0;
    end else begin
      longint n, s;
      bit     tk;
      tk    = (m_acc + m_add) >= 64'h1_0000_0000;
      m_acc = (m_acc + m_add) & 64'hFFFF_FFFF;
      if (init_pulse) begin
        m_sec = m_hsec; m_ns = m_hns;
      end else if (adj_pulse || tk) begin
        n = m_ns + (tk ? longint'(incr_ns) : 0);
        s = m_sec;
        if (adj_pulse) begin
          if (adj_sub) begin n = n - m_hns; s = s - m_hsec; end
          else         begin n = n + m_hns; s = s + m_hsec; end
        end
        if (n < 0)                begin n = n + 1000000000; s = s - 1; end
        else if (n >= 1000000000) begin n = n - 1000000000; s = s + 1; end
        m_ns = n; m_sec = s & 64'hFFFF_FFFF;
      end
      if (addend_we) m_add = addend_wdata;
      if (stage_we) begin m_hsec = stage_sec; m_hns = stage_ns; end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (time_sec != m_sec[31:0] || time_ns != m_ns[31:0] || tick != m_tick) begin
        errors++;
        $display("FAIL %s: sec=%0d ns=%0d tick=%0b expected sec=%0d ns=%0d tick=%0b",
                 req, time_sec, time_ns, tick, m_sec, m_ns, m_tick);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      addend_we = 0; stage_we = 0; init_pulse = 0; adj_pulse = 0;
    end
  endtask

  task automatic set_addend(input logic [31:0] v);
    @(negedge clk); addend_we = 1; addend_wdata = v;
    idle(1);
  endtask

  task automatic stage(input logic [31:0] s, input logic [31:0] n);
    @(negedge clk); stage_we = 1; stage_sec = s; stage_ns = n;
    idle(1);
  endtask

  task automatic pulse(input bit ini, input bit adj, input bit sub);
    @(negedge clk); init_pulse = ini; adj_pulse = adj; adj_sub = sub;
    idle(1);
  endtask

  task automatic wait_tick(input bit want);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (m_tick == want) break;
    end
  endtask

  initial begin
    rst_n = 0; addend_we = 0; addend_wdata = 0; incr_ns = 8'd10;
    stage_we = 0; stage_sec = 0; stage_ns = 0;
    init_pulse = 0; adj_pulse = 0; adj_sub = 0;
    repeat (3) @(negedge clk);
    req = "R1";
    rst_n = 1;
    idle(6);

    req = "R5"; set_addend(32'h4000_0000); idle(20);
    req = "R7"; incr_ns = 8'd250; idle(12);

    req = "R2"; stage(32'd100, 32'd999_999_900); pulse(1, 0, 0); idle(4);
    req = "R8"; idle(12);

    req = "R3"; stage(32'd5, 32'd600_000_000);
    wait_tick(0); init_pulse = 0; adj_pulse = 1; adj_sub = 0; idle(1); idle(4);
    req = "R4"; stage(32'd2, 32'd900_000_000);
    wait_tick(0); adj_pulse = 1; adj_sub = 1; idle(1); idle(4);
    stage(32'd200, 32'd0); wait_tick(0); adj_pulse = 1; adj_sub = 1; idle(1); idle(4);

    req = "R10"; stage(32'd1, 32'd999_999_990);
    wait_tick(1); adj_pulse = 1; adj_sub = 0; idle(1); idle(3);
    wait_tick(1); adj_pulse = 1; adj_sub = 1; idle(1); idle(3);

    req = "R9"; stage(32'd7, 32'd123);
    @(negedge clk); init_pulse = 1; adj_pulse = 1; adj_sub = 0; idle(1); idle(3);
    wait_tick(1); init_pulse = 1; idle(1); idle(3);

    req = "R6"; set_addend(32'hC000_0001); idle(10);
    @(negedge clk); addend_we = 1; addend_wdata = 32'h0000_0001; idle(1); idle(10);
    set_addend(32'hFFFF_FFFF); idle(16);

    req = "R1"; incr_ns = 8'd3; set_addend(32'h2000_0000); idle(200);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL %s: watchdog expired, actual running expected finished", req);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule